// File: doc/BRIEF.md
# Shared-Polynomial Random and CRC16 Engine

This block holds one 16-bit polynomial register with feedback taps x^16 + x^15 + x^2 + 1. It serves two uses. It hands out pseudo-random bytes to a processor or to a command sequencer. It also folds bytes into a CRC16. All the next-state logic is built from one parameterized unrolled chain of single steps. The chain is instantiated three times: 13 steps for a fresh random byte, 1 step for a manual single step, and 8 steps with data input for one CRC byte.

A 2-bit mode field picks how the register advances without data:
- In auto mode, a read strobe from the sequencer advances the register.
- In step mode, the register advances once and the field then returns to auto by itself.
- In the two hold encodings, the register is frozen.

Seed writes and CRC byte writes act in every mode and take precedence over any advance. Both register halves and the mode field come straight from flops.

Top module: `lfsr_crc_engine`

## Requirements
- R1: After synchronous reset, the register reads 0x0000 (`lfsr_hi` and `lfsr_lo`) and `mode_q` reads 00.
- R2: A cycle with `mode_wr` high loads `mode_wdata` into the mode field, and `mode_q` shows it after that clock edge.
- R3: With mode 00, a cycle with `rd_strobe` high advances the register by 13 single steps in one clock, so a new random byte is on `lfsr_lo` the next cycle. A cycle without a strobe and without writes leaves the register unchanged.
- R4: With mode 01, the first cycle without a seed or CRC write advances the register by exactly one step. In that same edge, the mode field becomes 00, unless `mode_wr` loads a new value in that cycle.
- R5: With mode 10 or 11, the register holds its value even when `rd_strobe` is high.
- R6: A seed write moves the old low byte into the high byte and puts `seed_byte` into the low byte, in any mode. Two writes set all 16 bits.
- R7: A CRC write folds `crc_byte` into the register MSB first, as 8 steps in one clock. Writes are accepted every cycle and act in any mode. From a seed of 0x0000, the bytes of the ASCII string "123456789" leave 0xFEE8.
- R8: The priority order is seed write first, then CRC write, then the mode-driven advance. A dropped auto advance is lost. A pending mode-01 step waits and keeps the mode field at 01.
- R9: One step shifts the register left by one bit. The feedback bit is old bit 15 XOR the input bit (0 for random steps), and it is XORed with 0x8005 into the shifted value. So 0x8000 steps to 0x8005 and 0x0001 steps to 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | New mode value (00 auto, 01 step, 10/11 hold) |
| rd_strobe | input | 1 | Sequencer read of the random byte; advances in auto mode |
| seed_wr | input | 1 | Seed byte write strobe |
| seed_byte | input | 8 | Seed byte |
| crc_wr | input | 1 | CRC byte write strobe |
| crc_byte | input | 8 | Byte folded into the CRC, MSB first |
| mode_q | output | 2 | Current mode field |
| lfsr_hi | output | 8 | Register bits 15:8 |
| lfsr_lo | output | 8 | Register bits 7:0; the random byte |

## Verification
Every result of this block appears one clock edge after the cycle that caused it:
- a seed load, a CRC fold and a 13-step advance;
- the one-step advance of mode 01 together with its return to 00.

The driver presents a stimulus for exactly one cycle and records the expected register and mode just after that edge. The monitor compares them at the following falling edge, so every check lands on the first cycle a change can be seen. For held or dropped operations, the bench checks the unchanged value over the next cycle. The CRC result is also compared against the published check value for the nine-digit string.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RAND_STEPS = 13;
  localparam logic [REG_W-1:0] POLY_DEFAULT = 16'h8005;

  typedef enum logic [1:0] {
    MODE_AUTO = 2'b00,
    MODE_STEP = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_OFF  = 2'b11
  } mode_e;
endpackage

// File: rtl/lfsr_unroll.sv
module lfsr_unroll #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 8,
  parameter logic [W-1:0] POLY = 16'h8005
) (
  input  logic [W-1:0] s_in,
  input  logic [N-1:0] din,   // consumed from bit N-1 down to bit 0
  output logic [W-1:0] s_out
);
  logic [W-1:0] chain [0:N];
  assign chain[0] = s_in;

  for (genvar g = 0; g < N; g++) begin : g_step
    logic fb;
    assign fb = chain[g][W-1] ^ din[N-1-g];
    assign chain[g+1] = {chain[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign s_out = chain[N];
endmodule

// File: rtl/lfsr_mode_ctrl.sv
module lfsr_mode_ctrl
  import lfsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       step_done,
  output mode_e      mode_q
);
  always_ff @(posedge clk) begin
    if (rst)             mode_q <= MODE_AUTO;
    else if (mode_wr)    mode_q <= mode_e'(mode_wdata);
    else if (step_done)  mode_q <= MODE_AUTO;
  end

  p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (mode_q == mode_e'($past(mode_wdata))));

  p_step_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (step_done && !mode_wr) |=> (mode_q == MODE_AUTO));

  p_step_only_in_step_mode_r4: assert property (@(posedge clk) disable iff (rst)
    step_done |-> (mode_q == MODE_STEP));
endmodule

// File: rtl/lfsr_crc_engine.sv
module lfsr_crc_engine
  import lfsr_pkg::*;
#(
  parameter int unsigned W          = REG_W,
  parameter int unsigned BW         = BYTE_W,
  parameter int unsigned RSTEPS     = RAND_STEPS,
  parameter logic [W-1:0] POLY      = POLY_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [1:0]    mode_wdata,
  input  logic          rd_strobe,
  input  logic          seed_wr,
  input  logic [BW-1:0] seed_byte,
  input  logic          crc_wr,
  input  logic [BW-1:0] crc_byte,
  output logic [1:0]    mode_q,
  output logic [BW-1:0] lfsr_hi,
  output logic [BW-1:0] lfsr_lo
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] state_q, state_d;
  logic [W-1:0] rand_next, step_next, crc_next;
  logic         data_wr, step_done;
  mode_e        mode;

  assign data_wr   = seed_wr | crc_wr;
  assign step_done = (mode == MODE_STEP) && !data_wr;

  lfsr_unroll #(.W(W), .N(RSTEPS), .POLY(POLY)) u_rand (
    .s_in(state_q), .din('0), .s_out(rand_next));

  lfsr_unroll #(.W(W), .N(1), .POLY(POLY)) u_single (
    .s_in(state_q), .din(1'b0), .s_out(step_next));

  lfsr_unroll #(.W(W), .N(BW), .POLY(POLY)) u_crc (
    .s_in(state_q), .din(crc_byte), .s_out(crc_next));

  lfsr_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .step_done(step_done), .mode_q(mode));

  always_comb begin
    state_d = state_q;
    if (seed_wr)
      state_d = {state_q[HALF-1:0], seed_byte};
    else if (crc_wr)
      state_d = crc_next;
    else begin
      unique case (mode)
        MODE_AUTO: if (rd_strobe) state_d = rand_next;
        MODE_STEP: state_d = step_next;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign mode_q  = mode;
  assign lfsr_hi = state_q[W-1:HALF];
  assign lfsr_lo = state_q[HALF-1:0];

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state_q == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_AUTO && !rd_strobe && !data_wr) |=> $stable(state_q));

  p_hold_modes_r5: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !data_wr) |=> $stable(state_q));

  p_seed_shift_r6: assert property (@(posedge clk) disable iff (rst)
    seed_wr |=> ({lfsr_hi, lfsr_lo} == {$past(lfsr_lo), $past(seed_byte)}));

  p_pending_step_waits_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STEP && data_wr && !mode_wr) |=> (mode_q == 2'b01));
endmodule

// File: tb/sim_lfsr_crc_engine.sv
module sim_lfsr_crc_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 0, rd_strobe = 0, seed_wr = 0, crc_wr = 0;
  logic [1:0] mode_wdata = 0;
  logic [7:0] seed_byte = 0, crc_byte = 0;
  logic [1:0] mode_q;
  logic [7:0] lfsr_hi, lfsr_lo;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [17:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m_st = 16'h0000;
  logic [1:0]  m_md = 2'b00;

  always #2 clk = ~clk;

  lfsr_crc_engine u0 (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rd_strobe(rd_strobe), .seed_wr(seed_wr), .seed_byte(seed_byte),
    .crc_wr(crc_wr), .crc_byte(crc_byte), .mode_q(mode_q),
    .lfsr_hi(lfsr_hi), .lfsr_lo(lfsr_lo));

  function automatic logic [15:0] one_step(logic [15:0] s, logic b);
    logic f;
    f = s[15] ^ b;
    s = s << 1;
    if (f) s = s ^ 16'h8005;
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [17:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {14'd0, mode_q, lfsr_hi, lfsr_lo}, {14'd0, e});
    end
  end

  // driver: one cycle of stimulus, model updated and expectation queued
  task automatic op(string tag, logic mw, logic [1:0] md, logic rd,
                    logic sw, logic [7:0] sb, logic cw, logic [7:0] cb);
    logic [15:0] ns;
    logic [1:0]  nm;
    @(negedge clk);
    mode_wr = mw; mode_wdata = md; rd_strobe = rd;
    seed_wr = sw; seed_byte = sb; crc_wr = cw; crc_byte = cb;
    ns = m_st; nm = m_md;
    if (sw) ns = {m_st[7:0], sb};
    else if (cw) begin
      for (int i = 7; i >= 0; i--) ns = one_step(ns, cb[i]);
    end else if (m_md == 2'b00) begin
      if (rd) for (int i = 0; i < 13; i++) ns = one_step(ns, 1'b0);
    end else if (m_md == 2'b01) begin
      ns = one_step(ns, 1'b0);
      nm = 2'b00;
    end
    if (mw) nm = md;
    @(posedge clk);
    #1;
    m_st = ns; m_md = nm;
    exp_q.push_back({m_md, m_st});
    tag_q.push_back(tag);
    mode_wr = 0; rd_strobe = 0; seed_wr = 0; crc_wr = 0;
  endtask

  task automatic idle(string tag);
    op(tag, 0, 2'b00, 0, 0, 8'h00, 0, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    string msg;
    msg = "123456789";
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 reset", {14'd0, mode_q, lfsr_hi, lfsr_lo}, 32'h0);
    idle("R1 idle after reset");

    // R9 step form: 0x8000 -> 0x8005 in mode 01, then mode back to 00 (R4)
    op("R6 seed hi", 0, 0, 0, 1, 8'h80, 0, 0);
    op("R6 seed lo", 0, 0, 0, 1, 8'h00, 0, 0);
    op("R2 mode write 01", 1, 2'b01, 0, 0, 0, 0, 0);
    idle("R4 R9 single step 8000");
    @(negedge clk);
    check("R9 8000 steps to 8005", {16'd0, lfsr_hi, lfsr_lo}, 32'h8005);
    check("R4 mode cleared", {30'd0, mode_q}, 32'd0);
    op("R6 seed 00", 0, 0, 0, 1, 8'h00, 0, 0);
    op("R6 seed 01", 0, 0, 0, 1, 8'h01, 0, 0);
    op("R2 mode 01 again", 1, 2'b01, 0, 0, 0, 0, 0);
    idle("R9 0001 steps to 0002");
    idle("R4 no second step");

    // R3 auto mode
    op("R6 seed A5", 0, 0, 0, 1, 8'hA5, 0, 0);
    op("R6 seed 3C", 0, 0, 0, 1, 8'h3C, 0, 0);
    op("R3 read advance", 0, 0, 1, 0, 0, 0, 0);
    op("R3 read advance 2", 0, 0, 1, 0, 0, 0, 0);
    idle("R3 hold without strobe");

    // R5 hold modes
    op("R2 mode 11", 1, 2'b11, 0, 0, 0, 0, 0);
    op("R5 off ignores strobe", 0, 0, 1, 0, 0, 0, 0);
    op("R6 seed in off mode", 0, 0, 0, 1, 8'h77, 0, 0);
    op("R2 mode 10", 1, 2'b10, 0, 0, 0, 0, 0);
    op("R5 reserved ignores strobe", 0, 0, 1, 0, 0, 0, 0);
    idle("R5 reserved hold");

    // R7 CRC of "123456789" from 0x0000, back to back
    op("R2 mode 00", 1, 2'b00, 0, 0, 0, 0, 0);
    op("R6 seed 0 a", 0, 0, 0, 1, 8'h00, 0, 0);
    op("R6 seed 0 b", 0, 0, 0, 1, 8'h00, 0, 0);
    for (int i = 0; i < 9; i++) op("R7 crc byte", 0, 0, 0, 0, 0, 1, msg[i]);
    @(negedge clk);
    check("R7 crc check value", {16'd0, lfsr_hi, lfsr_lo}, 32'hFEE8);
    op("R6 seed FF a", 0, 0, 0, 1, 8'hFF, 0, 0);
    op("R6 seed FF b", 0, 0, 0, 1, 8'hFF, 0, 0);
    op("R7 crc from FFFF 1", 0, 0, 0, 0, 0, 1, 8'h00);
    op("R7 crc from FFFF 2", 0, 0, 0, 0, 0, 1, 8'hFF);
    op("R7 crc in off mode", 1, 2'b11, 0, 0, 0, 0, 0);
    op("R7 crc while held", 0, 0, 0, 0, 0, 1, 8'h5A);

    // R8 priority
    op("R2 mode 00 for R8", 1, 2'b00, 0, 0, 0, 0, 0);
    op("R8 seed beats crc and read", 0, 0, 1, 1, 8'h42, 1, 8'h99);
    op("R8 crc beats read", 0, 0, 1, 0, 0, 1, 8'h13);
    idle("R8 dropped advance not replayed");
    op("R2 mode 01 for R8", 1, 2'b01, 0, 0, 0, 0, 0);
    op("R8 step waits on crc", 0, 0, 0, 0, 0, 1, 8'hC3);
    op("R8 step waits on seed", 0, 0, 0, 1, 8'h11, 0, 0);
    idle("R8 R4 pending step runs");
    idle("R4 settled");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule